// File: doc/BRIEF.md
# Complex Multiplier with Booth Recoding and Carry-Save Reduction

This block multiplies two complex numbers whose real and imaginary parts are signed two's-complement words. Four real products are formed in parallel: the product of the real parts, the product of the imaginary parts, and the two cross products. The real result is the real-parts product minus the imaginary-parts product. The imaginary result is the sum of the two cross products.

Each real product recodes its multiplier into radix-4 signed digits, so a 16-bit operand gives eight partial products instead of sixteen. An extra row holds the +1 corrections of the negated rows. The rows are then reduced by a tree of 3:2 carry-save adders until two remain, and a single carry-propagate add finishes the product. The results are one bit wider than the products, so the final subtract and add can never overflow.

A caller presents the four operand words with an input strobe. The results appear in a register one clock later, together with an output strobe.

Top module: `cmul_booth_wallace`

## Requirements
- R1: When `in_valid` is sampled high, `re_o` one clock later equals a_re·b_re − a_im·b_im, exact as a 33-bit signed value.
- R2: When `in_valid` is sampled high, `im_o` one clock later equals a_re·b_im + a_im·b_re, exact as a 33-bit signed value.
- R3: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was sampled high, and low otherwise.
- R4: While `in_valid` is low, `re_o` and `im_o` keep their last values, whatever the operand inputs do.
- R5: `rst` is synchronous and active high. At the clock edge where it is sampled high, `out_valid`, `re_o` and `im_o` all go to zero.
- R6: Operands at the extremes of the range (−32768 and 32767, in every combination) give exact results with no overflow, including −32768·−32768 = 2^30.
- R7: Every radix-4 digit value (0, ±1, ±2) gives exact products. Multiplier bit patterns made of alternating bits, long runs of ones and isolated bits (0x5555, 0xAAAA, 0xFFFF, 0x7FFF, 0x8000, 0x0001, 0x3333, 0xCCCC) are all covered.
- R8: With `in_valid` held high on consecutive cycles, every operand set gives its own correct result one cycle later, with no skipped or repeated outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_re | input | 16 | Real part of first operand, signed |
| a_im | input | 16 | Imaginary part of first operand, signed |
| b_re | input | 16 | Real part of second operand, signed |
| b_im | input | 16 | Imaginary part of second operand, signed |
| out_valid | output | 1 | Results are valid this cycle |
| re_o | output | 33 | Real part of the product, signed |
| im_o | output | 33 | Imaginary part of the product, signed |

## Verification
The bench feeds multiplier words that exercise each recoded digit. A design that decodes +2A or −2A wrongly, or drops the neighbouring bit of the lowest group, gives wrong products for 0x5555, 0xAAAA or 0xCCCC. The extreme operands catch three faults: a design that omits the +1 correction of negated rows, one that fails to sign-extend the partial products, and one that leaves the outputs at 32 bits. These show up as off-by-small errors or wrapped signs at −32768·−32768 and at the largest real sum. Streaming and hold phases catch a strobe that is off by one cycle and results that drift while the strobe is low. A mid-run reset shows whether the output register truly clears.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // result of one 3:2 carry-save step
  typedef struct packed {
    logic [63:0] s;
    logic [63:0] c;
  } csa_pair_t;

  // number of rows left after one level of 3:2 reduction
  function automatic int rows_after(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // number of 3:2 levels needed to reach two rows
  function automatic int csa_levels(input int n);
    int k;
    int cnt;
    k = n;
    cnt = 0;
    while (k > 2) begin
      k = rows_after(k);
      cnt++;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/booth_ppgen.sv
module booth_ppgen #(
  parameter int N = 16,
  localparam int W = 2 * N,
  localparam int G = N / 2,
  localparam int ROWS = G + 1
) (
  input  logic [N-1:0]           mcand,
  input  logic [N-1:0]           mplier,
  output logic [ROWS-1:0][W-1:0] pp
);

  logic [N:0]   mx;        // multiplier with implicit zero below bit 0
  logic [W-1:0] a_ext;
  logic [G-1:0] neg_bits;
  logic [W-1:0] corr_row;

  assign mx    = {mplier, 1'b0};
  assign a_ext = {{(W-N){mcand[N-1]}}, mcand};

  for (genvar g = 0; g < G; g++) begin : gen_grp
    logic [2:0]   trip;
    logic         sel1;
    logic         sel2;
    logic         negd;
    logic [W-1:0] mag;
    logic [W-1:0] flip;

    assign trip = mx[2*g+2 : 2*g];
    assign sel1 = trip[1] ^ trip[0];
    assign sel2 = (trip == 3'b011) || (trip == 3'b100);
    assign negd = trip[2] & ~(trip[1] & trip[0]);

    always_comb begin
      if (sel1)      mag = a_ext;
      else if (sel2) mag = a_ext << 1;
      else           mag = '0;
    end

    assign flip        = negd ? ~mag : mag;
    assign pp[g]       = flip << (2 * g);
    assign neg_bits[g] = negd;
  end

  // +1 at each negated row's own weight, gathered in one extra row
  always_comb begin
    corr_row = '0;
    for (int g = 0; g < G; g++) corr_row[2*g] = neg_bits[g];
  end

  assign pp[G] = corr_row;

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import cmul_pkg::*;
#(
  parameter int W = 32,
  parameter int ROWS = 9
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);

  localparam int NLVL = csa_levels(ROWS);
  localparam int MAXG = ROWS / 3;

  logic [W-1:0] cur [ROWS];
  logic [W-1:0] nxt [ROWS];

  always_comb begin
    int n;
    for (int r = 0; r < ROWS; r++) cur[r] = rows[r];
    for (int r = 0; r < ROWS; r++) nxt[r] = '0;
    n = ROWS;
    for (int l = 0; l < NLVL; l++) begin
      for (int r = 0; r < ROWS; r++) nxt[r] = '0;
      // 3:2 compressors on each full triple of rows
      for (int g = 0; g < MAXG; g++) begin
        if (g < n / 3) begin
          nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
          nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) |
                        (cur[3*g] & cur[3*g+2]) |
                        (cur[3*g+1] & cur[3*g+2])) << 1;
        end
      end
      // rows not in a full triple pass to the next level
      for (int k = 0; k < 2; k++) begin
        if (k < n % 3) nxt[2*(n/3)+k] = cur[3*(n/3)+k];
      end
      n = rows_after(n);
      for (int r = 0; r < ROWS; r++) cur[r] = nxt[r];
    end
  end

  assign sum_o   = cur[0];
  assign carry_o = cur[1];

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int N = 16,
  localparam int W = 2 * N,
  localparam int ROWS = N / 2 + 1
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [W-1:0] prod
);

  logic [ROWS-1:0][W-1:0] pp;
  logic [W-1:0]           s_vec;
  logic [W-1:0]           c_vec;

  booth_ppgen #(.N(N)) u_ppgen (
    .mcand (x),
    .mplier(y),
    .pp    (pp)
  );

  csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows   (pp),
    .sum_o  (s_vec),
    .carry_o(c_vec)
  );

  // the only carry-propagate add of the product
  assign prod = s_vec + c_vec;

endmodule

// File: rtl/cmul_booth_wallace.sv
module cmul_booth_wallace #(
  parameter int N = 16,
  localparam int P = 2 * N,
  localparam int R = 2 * N + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] a_re,
  input  logic [N-1:0] a_im,
  input  logic [N-1:0] b_re,
  input  logic [N-1:0] b_im,
  output logic         out_valid,
  output logic [R-1:0] re_o,
  output logic [R-1:0] im_o
);

  // product slots: 0 re*re, 1 im*im, 2 re*im, 3 im*re
  logic [3:0][N-1:0] mx;
  logic [3:0][N-1:0] my;
  logic [3:0][P-1:0] pr;
  logic [R-1:0]      re_c;
  logic [R-1:0]      im_c;

  assign mx = {a_im, a_re, a_im, a_re};
  assign my = {b_re, b_im, b_im, b_re};

  for (genvar k = 0; k < 4; k++) begin : gen_mul
    booth_mult #(.N(N)) u_mul (
      .x   (mx[k]),
      .y   (my[k]),
      .prod(pr[k])
    );
  end

  assign re_c = {pr[0][P-1], pr[0]} - {pr[1][P-1], pr[1]};
  assign im_c = {pr[2][P-1], pr[2]} + {pr[3][P-1], pr[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      re_o      <= '0;
      im_o      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        re_o <= re_c;
        im_o <= im_c;
      end
    end
  end

  // behavioural reference for the registered results
  logic signed [R-1:0] chk_re;
  logic signed [R-1:0] chk_im;
  assign chk_re = R'($signed(a_re) * $signed(b_re)) - R'($signed(a_im) * $signed(b_im));
  assign chk_im = R'($signed(a_re) * $signed(b_im)) + R'($signed(a_im) * $signed(b_re));

  // R1
  re_exact_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (re_o == $past(chk_re)));

  // R2
  im_exact_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (im_o == $past(chk_im)));

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R3
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(re_o) && $stable(im_o)));

endmodule

// File: tb/cmul_booth_wallace_tb.sv
module cmul_booth_wallace_tb;

  logic        clk;
  logic        rst;
  logic        in_valid;
  logic [15:0] a_re, a_im, b_re, b_im;
  logic        out_valid;
  logic [32:0] re_o, im_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  cmul_booth_wallace u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .re_o(re_o), .im_o(im_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [32:0] ref_re(input logic [15:0] ar, ai, br, bi);
    longint v;
    v = longint'($signed(ar)) * longint'($signed(br)) - longint'($signed(ai)) * longint'($signed(bi));
    return v[32:0];
  endfunction

  function automatic logic [32:0] ref_im(input logic [15:0] ar, ai, br, bi);
    longint v;
    v = longint'($signed(ar)) * longint'($signed(bi)) + longint'($signed(ai)) * longint'($signed(br));
    return v[32:0];
  endfunction

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one vector: drive at negedge, check at the following negedge
  task automatic one_vec(input string req, input logic [15:0] ar, ai, br, bi);
    @(negedge clk);
    a_re = ar; a_im = ai; b_re = br; b_im = bi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R3 valid"}, {32'd0, out_valid}, 33'd1);
    chk({req, " R1 real"}, re_o, ref_re(ar, ai, br, bi));
    chk({req, " R2 imag"}, im_o, ref_im(ar, ai, br, bi));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R5 reset valid", {32'd0, out_valid}, 33'd0);
    chk("R5 reset real", re_o, 33'd0);
    chk("R5 reset imag", im_o, 33'd0);
  endtask

  task automatic t_basic();
    one_vec("basic", 16'd3, 16'd4, 16'd5, 16'd6);
    one_vec("basic", 16'hFFFD, 16'd7, 16'd2, 16'hFFF0);
    one_vec("basic", 16'd0, 16'd0, 16'd1234, 16'hBEEF);
    one_vec("basic", 16'd1000, 16'hFC18, 16'hFC18, 16'd1000);
  endtask

  task automatic t_corner();
    // R6 extremes of the signed range
    one_vec("R6", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    one_vec("R6", 16'h8000, 16'h8000, 16'h8000, 16'h7FFF);
    one_vec("R6", 16'h8000, 16'h7FFF, 16'h8000, 16'h8000);
    one_vec("R6", 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000);
    one_vec("R6", 16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF);
    one_vec("R6", 16'h8000, 16'h0000, 16'h8000, 16'h0000);
  endtask

  task automatic t_digits();
    logic [15:0] pats [8] = '{16'h5555, 16'hAAAA, 16'hFFFF, 16'h7FFF,
                              16'h8000, 16'h0001, 16'h3333, 16'hCCCC};
    for (int i = 0; i < 8; i++) begin
      one_vec("R7", 16'h8000, 16'h7FFF, pats[i], pats[7-i]);
      one_vec("R7", 16'h1357, 16'hE9B1, pats[i], pats[i]);
    end
  endtask

  task automatic t_hold();
    logic [32:0] kr, ki;
    one_vec("hold setup", 16'd321, 16'hFF00, 16'd77, 16'h0100);
    kr = re_o; ki = im_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      a_re = 16'h7FFF - 16'(i); a_im = 16'h1111; b_re = 16'h8000; b_im = 16'h2222;
      in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R4 hold real", re_o, kr);
    chk("R4 hold imag", im_o, ki);
    chk("R3 idle valid", {32'd0, out_valid}, 33'd0);
  endtask

  task automatic t_stream();
    logic [15:0] pr, pi, qr, qi;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R8 stream valid", {32'd0, out_valid}, 33'd1);
        chk("R8 stream real", re_o, ref_re(pr, pi, qr, qi));
        chk("R8 stream imag", im_o, ref_im(pr, pi, qr, qi));
      end
      pr = 16'($urandom); pi = 16'($urandom); qr = 16'($urandom); qi = 16'($urandom);
      a_re = pr; a_im = pi; b_re = qr; b_im = qi; in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 stream last real", re_o, ref_re(pr, pi, qr, qi));
    chk("R8 stream last imag", im_o, ref_im(pr, pi, qr, qi));
  endtask

  task automatic t_midreset();
    one_vec("reset setup", 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk("R5 midrun valid", {32'd0, out_valid}, 33'd0);
    chk("R5 midrun real", re_o, 33'd0);
    chk("R5 midrun imag", im_o, 33'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_basic();
    t_corner();
    t_digits();
    t_hold();
    t_stream();
    t_midreset();
    t_basic();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule